// File: doc/BRIEF.md
# Legacy VGA Access Routing Decoder

This block sits on the host side of a chip and decides where each incoming host cycle goes. A cycle is sent either to the integrated graphics engine or onward to the downstream bridge port. Two kinds of cycle are decoded:

- **Memory cycles** that fall in the legacy frame-buffer window, A0000h to BFFFFh.
- **I/O cycles** that fall in the VGA register ranges.

Which cycles the graphics engine claims depends on two things. One is a set of device-level enable bits. The other is two fields that the VGA software stack programs: a two-bit memory-map mode, and a miscellaneous-output byte. That byte carries the compatibility-memory enable and the I/O base select. A small configuration port writes these values. The routing decision comes out registered, one clock after the request. It carries a valid flag and an echo of the request direction.

Anything that is not claimed goes to the bridge port. This covers cycles outside the legacy windows, cycles whose enables are not all set, and slices that the selected mode leaves out.

Top module: `vga_route_decoder`

## Requirements
- R1: After reset every enable, the mode field and both miscellaneous bits read as zero. `outValid` is 0 and `outToGfx` is 0, so every request is forwarded until configuration is written.
- R2: `outValid` equals `reqValid` of the previous cycle. `outWrite` equals `reqWrite` of the previous cycle when valid, and direction never changes the route. `outToGfx` is 0 whenever `outValid` is 0.
- R3: A memory cycle is sent to graphics only if all four of these bits are 1: device enable, VGA enable, memory-access enable and compatibility-memory enable.
- R4: The mode field selects the claimed memory window:
  - 0 claims A0000h–BFFFFh.
  - 1 claims A0000h–AFFFFh.
  - 2 claims B0000h–B7FFFh.
  - 3 claims B8000h–BFFFFh.
- R5: Memory addresses outside the window claimed by the mode are forwarded (`outToGfx`=0). This includes addresses whose bits above bit 19 are not all zero.
- R6: An I/O cycle is sent to graphics only if device enable, VGA enable and I/O-access enable are all 1. The compatibility-memory bit does not take part.
- R7: I/O decode compares address bits 15:0 exactly. An I/O address in 0400h–FFFFh never matches, even when its low 10 bits equal a VGA port.
- R8: With I/O decode enabled, 03C0h–03CFh is always sent to graphics, whatever the I/O base select.
- R9: With I/O base select 0, 03B0h–03BBh goes to graphics and 03D0h–03DFh is forwarded. With select 1 it is the other way round.
- R10: 03BCh–03BFh is always forwarded.
- R11: A configuration write changes routing for requests presented on the following cycle or later. A request presented in the same cycle as the write is routed with the old settings.
- R12: The configuration port uses `cfgSel` to choose a register:
  - `cfgSel`=0 writes the enables: bit0 device, bit1 VGA, bit2 memory access, bit3 I/O access.
  - `cfgSel`=1 writes the mode from `cfgData[1:0]`.
  - `cfgSel`=2 writes the miscellaneous bits: bit0 I/O base select, bit1 compatibility-memory enable.
  - `cfgSel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqIsIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgData | input | 4 | Configuration write data |
| outValid | output | 1 | Decision valid (one cycle after the request) |
| outToGfx | output | 1 | 1 = graphics, 0 = bridge port |
| outWrite | output | 1 | Direction of the decided request |

## Verification
The bench sweeps every combination of the four enables, the four modes and both miscellaneous bits. Under each combination it sends requests at the first and last address of every memory slice and I/O range, and also at addresses just outside them.

- A design that mis-decodes a window edge, such as B7FFFh against B8000h, or 03BBh against 03BCh, sends a boundary address the wrong way.
- A design that decodes only ten I/O address bits claims 13C0h and 83D4h.
- A design that lets the compatibility-memory bit gate I/O cycles, or forgets it on memory cycles, fails the half of the sweep where that bit differs.

A dedicated sequence writes configuration in the same cycle as a request. A design that bypasses the new value into the decision routes that request with the wrong settings. A write to the unused selector must leave routing unchanged.

// File: rtl/vga_route_pkg.sv
package vga_route_pkg;

  localparam int CFG_W = 4;
  localparam int SEL_W = 2;

  // configuration register selectors
  localparam logic [SEL_W-1:0] SEL_ENABLES = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MODE    = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MISC    = 2'd2;

  // claim strobes handed from control to the datapath
  typedef struct packed {
    logic memA;   // A0000-AFFFF
    logic memB0;  // B0000-B7FFF
    logic memB8;  // B8000-BFFFF
    logic io3B;   // 03B0-03BB
    logic io3C;   // 03C0-03CF
    logic io3D;   // 03D0-03DF
  } claimStrobes_t;

endpackage

// File: rtl/vga_route_ctrl.sv
module vga_route_ctrl
  import vga_route_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  output claimStrobes_t    claims
);

  logic       devEn, vgaEn, memEn, ioEn;
  logic [1:0] mapMode;
  logic       ioSelect, compatMem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devEn     <= 1'b0;
      vgaEn     <= 1'b0;
      memEn     <= 1'b0;
      ioEn      <= 1'b0;
      mapMode   <= 2'b00;
      ioSelect  <= 1'b0;
      compatMem <= 1'b0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_ENABLES: begin
          devEn <= cfgData[0];
          vgaEn <= cfgData[1];
          memEn <= cfgData[2];
          ioEn  <= cfgData[3];
        end
        SEL_MODE: mapMode <= cfgData[1:0];
        SEL_MISC: begin
          ioSelect  <= cfgData[0];
          compatMem <= cfgData[1];
        end
        default: ;
      endcase
    end
  end

  logic memOk, ioOk;

  always_comb begin
    memOk = devEn & vgaEn & memEn & compatMem;
    ioOk  = devEn & vgaEn & ioEn;

    claims.memA  = memOk & ((mapMode == 2'd0) | (mapMode == 2'd1));
    claims.memB0 = memOk & ((mapMode == 2'd0) | (mapMode == 2'd2));
    claims.memB8 = memOk & ((mapMode == 2'd0) | (mapMode == 2'd3));

    claims.io3C  = ioOk;
    claims.io3B  = ioOk & ~ioSelect;
    claims.io3D  = ioOk &  ioSelect;
  end

endmodule

// File: rtl/vga_route_dp.sv
module vga_route_dp
  import vga_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  claimStrobes_t     claims,
  output logic              outValid,
  output logic              outToGfx,
  output logic              outWrite
);

  localparam int TAG64_W = ADDR_W - 16;
  localparam int TAG32_W = ADDR_W - 15;
  localparam int PORT_W  = IO_W - 4;

  localparam logic [TAG64_W-1:0] TAG_A  = TAG64_W'(32'hA0000 >> 16);
  localparam logic [TAG32_W-1:0] TAG_B0 = TAG32_W'(32'hB0000 >> 15);
  localparam logic [TAG32_W-1:0] TAG_B8 = TAG32_W'(32'hB8000 >> 15);
  localparam logic [PORT_W-1:0]  PORT_3B = PORT_W'(12'h03B);
  localparam logic [PORT_W-1:0]  PORT_3C = PORT_W'(12'h03C);
  localparam logic [PORT_W-1:0]  PORT_3D = PORT_W'(12'h03D);

  logic [TAG64_W-1:0] tag64k;
  logic [TAG32_W-1:0] tag32k;
  logic [PORT_W-1:0]  portHi;
  logic [3:0]         portLo;
  logic hitA, hitB0, hitB8, hit3B, hit3C, hit3D;
  logic memGfx, ioGfx, routeGfx;

  always_comb begin
    tag64k = reqAddr[ADDR_W-1:16];
    tag32k = reqAddr[ADDR_W-1:15];
    portHi = reqAddr[IO_W-1:4];
    portLo = reqAddr[3:0];

    hitA  = (tag64k == TAG_A);
    hitB0 = (tag32k == TAG_B0);
    hitB8 = (tag32k == TAG_B8);
    hit3B = (portHi == PORT_3B) && (portLo <= 4'hB);
    hit3C = (portHi == PORT_3C);
    hit3D = (portHi == PORT_3D);

    memGfx = (hitA & claims.memA) | (hitB0 & claims.memB0) | (hitB8 & claims.memB8);
    ioGfx  = (hit3B & claims.io3B) | (hit3C & claims.io3C) | (hit3D & claims.io3D);
    routeGfx = reqValid & (reqIsIo ? ioGfx : memGfx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outToGfx <= 1'b0;
      outWrite <= 1'b0;
    end else begin
      outValid <= reqValid;
      outToGfx <= routeGfx;
      outWrite <= reqValid & reqWrite;
    end
  end

endmodule

// File: rtl/vga_route_decoder.sv
module vga_route_decoder
  import vga_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [3:0]        cfgData,
  output logic              outValid,
  output logic              outToGfx,
  output logic              outWrite
);

  claimStrobes_t claims;

  vga_route_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .cfgData (cfgData),
    .claims  (claims)
  );

  vga_route_dp #(.ADDR_W(ADDR_W), .IO_W(16)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqIsIo  (reqIsIo),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .claims   (claims),
    .outValid (outValid),
    .outToGfx (outToGfx),
    .outWrite (outWrite)
  );

endmodule

// File: rtl/vga_route_chk.sv
module vga_route_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqIsIo,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              outValid,
  input logic              outToGfx,
  input logic              outWrite
);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !outToGfx));

  // R2
  dir_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (outWrite == $past(reqWrite)));

  // R5
  mem_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsIo && (reqAddr[ADDR_W-1:17] != (ADDR_W-17)'(5))) |=> !outToGfx);

  // R7
  io_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsIo && (reqAddr[15:10] != 6'd0)) |=> !outToGfx);

  // R10
  io_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsIo && (reqAddr[15:2] == 14'h0EF)) |=> !outToGfx);

endmodule

bind vga_route_decoder vga_route_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqIsIo  (reqIsIo),
  .reqAddr  (reqAddr),
  .reqWrite (reqWrite),
  .outValid (outValid),
  .outToGfx (outToGfx),
  .outWrite (outWrite)
);

// File: tb/sim_vga_route_decoder.sv
`timescale 1ns/1ps
module sim_vga_route_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsIo = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [3:0]  cfgData = '0;
  logic        outValid, outToGfx, outWrite;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vga_route_decoder #(.ADDR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsIo(reqIsIo),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .outValid(outValid), .outToGfx(outToGfx), .outWrite(outWrite)
  );

  // arithmetic reference of the routing rules
  function automatic logic expGfx(input logic [3:0] en, input logic [1:0] mode,
                                  input logic [1:0] misc, input logic isIo,
                                  input logic [31:0] addr);
    logic inA, inB0, inB8, memOk, ioOk;
    int p;
    if (isIo) begin
      ioOk = en[0] & en[1] & en[3];
      p = int'(addr[15:0]);
      if (!ioOk) return 1'b0;
      if (p >= 'h3C0 && p <= 'h3CF) return 1'b1;
      if (p >= 'h3B0 && p <= 'h3BB) return !misc[0];
      if (p >= 'h3D0 && p <= 'h3DF) return misc[0];
      return 1'b0;
    end
    memOk = en[0] & en[1] & en[2] & misc[1];
    inA  = (addr >= 32'hA0000) && (addr <= 32'hAFFFF);
    inB0 = (addr >= 32'hB0000) && (addr <= 32'hB7FFF);
    inB8 = (addr >= 32'hB8000) && (addr <= 32'hBFFFF);
    case (mode)
      2'd0: return memOk & (inA | inB0 | inB8);
      2'd1: return memOk & inA;
      2'd2: return memOk & inB0;
      default: return memOk & inB8;
    endcase
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [3:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic checkReq(input logic isIo, input logic [31:0] addr, input logic wr,
                          input logic exp, input string tag);
    reqValid = 1'b1; reqIsIo = isIo; reqAddr = addr; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    tests++;
    if (outValid !== 1'b1 || outToGfx !== exp || outWrite !== wr) begin
      fails++;
      $display("FAIL %s io=%0b addr=%h: valid=%0b gfx=%0b wr=%0b expected valid=1 gfx=%0b wr=%0b",
               tag, isIo, addr, outValid, outToGfx, outWrite, exp, wr);
    end
  endtask

  task automatic checkIdle(input string tag);
    reqValid = 1'b0;
    @(negedge clk);
    tests++;
    if (outValid !== 1'b0 || outToGfx !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: valid=%0b gfx=%0b expected valid=0 gfx=0", tag, outValid, outToGfx);
    end
  endtask

  function automatic string tagFor(input logic [3:0] en, input logic [1:0] misc,
                                   input logic isIo, input logic [31:0] a);
    if (isIo) begin
      if (a[15:0] >= 16'h400) return "R7";
      if (a[15:0] >= 16'h3BC && a[15:0] <= 16'h3BF) return "R10";
      if (!(en[0] & en[1] & en[3])) return "R6";
      if (a[15:4] == 12'h03C) return "R8";
      return "R9";
    end
    if (a < 32'hA0000 || a > 32'hBFFFF) return "R5";
    if (!(en[0] & en[1] & en[2] & misc[1])) return "R3";
    return "R4";
  endfunction

  logic [31:0] memList [10] = '{32'h9FFFF, 32'hA0000, 32'hAFFFF, 32'hB0000, 32'hB7FFF,
                                32'hB8000, 32'hBFFFF, 32'hC0000, 32'h1A0000, 32'h0};
  logic [31:0] ioList [12] = '{32'h3AF, 32'h3B0, 32'h3BB, 32'h3BC, 32'h3BF, 32'h3C0,
                               32'h3CF, 32'h3D0, 32'h3DF, 32'h3E0, 32'h13C0, 32'h83D4};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    tests++;
    if (outValid !== 1'b0 || outToGfx !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: valid=%0b gfx=%0b expected 0 0", outValid, outToGfx);
    end
    // R1: unconfigured decoder forwards everything, even claimable addresses
    checkReq(1'b0, 32'hA0000, 1'b0, 1'b0, "R1");
    checkReq(1'b1, 32'h3C4, 1'b1, 1'b0, "R1");
    checkIdle("R2");

    // R12 sweep of the configuration space; R2 direction alternates
    for (int en = 0; en < 16; en++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int misc = 0; misc < 4; misc++) begin
          cfgWrite(2'd0, 4'(en));
          cfgWrite(2'd1, 4'(mode));
          cfgWrite(2'd2, 4'(misc));
          for (int i = 0; i < 10; i++)
            checkReq(1'b0, memList[i], 1'(i), expGfx(4'(en), 2'(mode), 2'(misc), 1'b0, memList[i]),
                     tagFor(4'(en), 2'(misc), 1'b0, memList[i]));
          for (int i = 0; i < 12; i++)
            checkReq(1'b1, ioList[i], 1'(i + 1), expGfx(4'(en), 2'(mode), 2'(misc), 1'b1, ioList[i]),
                     tagFor(4'(en), 2'(misc), 1'b1, ioList[i]));
        end
      end
      checkIdle("R2");
    end

    // R11: write in the same cycle as a request uses old settings
    cfgWrite(2'd1, 4'd1);
    cfgWrite(2'd2, 4'b0010);
    cfgWrite(2'd0, 4'b0000);
    cfgWe = 1'b1; cfgSel = 2'd0; cfgData = 4'b1111;
    checkReq(1'b0, 32'hA1234, 1'b0, 1'b0, "R11");
    cfgWe = 1'b0;
    checkReq(1'b0, 32'hA1234, 1'b0, 1'b1, "R11");

    // R12: selector 3 changes nothing
    cfgWrite(2'd3, 4'b0000);
    checkReq(1'b0, 32'hAFFF0, 1'b1, 1'b1, "R12");
    checkReq(1'b0, 32'hB8000, 1'b0, 1'b0, "R12");
    checkReq(1'b1, 32'h3B4, 1'b0, 1'b1, "R12");
    checkIdle("R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule